// File: doc/BRIEF.md
# Operand-Dependent Latency Floating-Point Divider

This block divides single-precision floating-point numbers over many cycles. How long it takes depends on the data. If a dividend or a divisor is zero, the answer is known at once, so the block finishes on a fixed short path. Every other operand pair goes through a restoring mantissa division that produces one quotient bit per cycle. Idle cycles are added after the loop so that the long path always takes the same number of cycles.

A caller presents the operands and pulses `start` while `busy` is low. It then waits for the one-cycle `done` pulse, at which `result` and `dz_flag` are valid. Those outputs keep their value until the next completion. When `vec_mode` is set, each operand holds two independent single-precision lanes. The short path is then taken only if every lane contains a zero operand.

The block makes these simplifications:
- Subnormal inputs are treated as zero.
- Rounding is toward zero.
- Infinity and NaN inputs are assumed not to occur.

Top module: `fdiv_early_out`

## Requirements
- R1: After reset, `busy`, `done`, `result` and `dz_flag` are all zero.
- R2: In scalar mode, if either lane-0 operand has a zero exponent field, `done` rises exactly 4 clock edges after the edge that accepts `start`.
- R3: In scalar mode, if both lane-0 operands are nonzero, `done` rises exactly 29 edges after acceptance.
- R4: In vector mode, the 4-edge latency applies only when lane 0 (bits 31:0) and lane 1 (bits 63:32) each have a zero operand. Otherwise the operation takes 29 edges.
- R5: `busy` is high from the cycle after acceptance until `done`, and is low while `done` is high. A `start` seen while `busy` is high is ignored: it produces no extra `done` and does not alter the running operation's result.
- R6: A zero dividend with a nonzero divisor gives a zero whose sign bit (bit 31 of the lane) is the XOR of the operand signs.
- R7: A nonzero dividend over a zero divisor gives infinity with the XOR sign (exponent field 0xFF, fraction 0). It also sets that lane's bit in `dz_flag`, where bit 0 is lane 0 and bit 1 is lane 1.
- R8: Zero divided by zero gives 0x7FC00000 and leaves the lane's `dz_flag` bit clear.
- R9: For nonzero operands, the fraction is the quotient truncated toward zero. The exponent is ea − eb + 127, reduced by one when the mantissa quotient is below 1.
- R10: A result exponent of 255 or more gives signed infinity with `dz_flag` clear. A result exponent of 0 or less gives signed zero.
- R11: An operand whose exponent field is 0 is handled as zero, whatever its fraction.
- R12: In scalar mode, bits 63:32 of the operands are ignored. `result[63:32]` and `dz_flag[1]` are zero after completion.
- R13: `done` is high for exactly one cycle per accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a divide; accepted when `busy` is low |
| vec_mode | input | 1 | 1 = two-lane vector operation, 0 = scalar on lane 0 |
| op_a | input | 64 | Dividends, lane 0 in bits 31:0, lane 1 in bits 63:32 |
| op_b | input | 64 | Divisors, same lane layout |
| busy | output | 1 | An operation is in flight |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Quotients, same lane layout |
| dz_flag | output | 2 | Per-lane divide-by-zero flag |

## Verification
The hardest condition to reach is a vector operation in which only one lane holds a zero operand. That lane must produce a special value while the whole operation still runs the full long path. The stimulus sends mixed-lane vector operands alongside all-zero-lane pairs, so both latency outcomes of the vector rule are measured. A second hard case is a `start` pulse issued with different operands in the middle of a long operation. The scoreboard then confirms that the running result is unchanged and that no extra completion appears.

// File: rtl/fdiv_pkg.sv
`timescale 1ns/1ps
// fdiv_pkg: shared constants, operand-class type and special-result encoder
// for the operand-dependent latency divider. Assumes IEEE single precision.
package fdiv_pkg;
    localparam int unsigned FP_W   = 32;
    localparam int unsigned EXP_W  = 8;
    localparam int unsigned FRAC_W = 23;
    localparam int unsigned MANT_W = FRAC_W + 1;

    typedef enum logic [1:0] {
        K_NORM = 2'd0,
        K_ZERO = 2'd1,
        K_INF  = 2'd2,
        K_NAN  = 2'd3
    } op_kind_e;

    // Encode a non-numeric outcome for a lane
    function automatic logic [FP_W-1:0] special_word(op_kind_e k, logic s);
        logic [FP_W-1:0] w;
        case (k)
            K_ZERO:  w = {s, {(FP_W-1){1'b0}}};
            K_INF:   w = {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            K_NAN:   w = 32'h7FC0_0000;
            default: w = '0;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/fdiv_ctrl.sv
`timescale 1ns/1ps
// fdiv_ctrl: sequencer for the divider. Accepts a request when idle, picks
// the short or long latency from the early flag, and counts mantissa steps.
// Assumes ITERS fits inside the long latency.
module fdiv_ctrl #(
    parameter int unsigned LAT_SHORT = 4,
    parameter int unsigned LAT_LONG  = 29,
    parameter int unsigned ITERS     = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic early,
    output logic busy,
    output logic done,
    output logic load,
    output logic step,
    output logic fin
);
    localparam int unsigned CNT_W = $clog2(LAT_LONG + 1);
    localparam int unsigned IT_W  = $clog2(ITERS + 1);

    logic             busy_q, done_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IT_W-1:0]  it_q;
    logic [CNT_W-1:0] chk_q;

    // Handshake decode
    always_comb begin
        load = start && !busy_q;
        fin  = busy_q && (cnt_q == '0);
        step = busy_q && (it_q != '0);
    end

    assign busy = busy_q;
    assign done = done_q;

    // Latency counter, step counter and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            it_q   <= '0;
        end else begin
            done_q <= fin;
            if (load) begin
                busy_q <= 1'b1;
                cnt_q  <= early ? CNT_W'(LAT_SHORT - 1) : CNT_W'(LAT_LONG - 1);
                it_q   <= IT_W'(ITERS);
            end else if (busy_q) begin
                if (cnt_q == '0) busy_q <= 1'b0;
                else             cnt_q  <= cnt_q - 1'b1;
                if (it_q != '0)  it_q   <= it_q - 1'b1;
            end
        end
    end

    // Checker counter: edges elapsed since acceptance
    always_ff @(posedge clk) begin
        if (!rst_n)      chk_q <= '0;
        else if (load)   chk_q <= '0;
        else if (busy_q) chk_q <= chk_q + 1'b1;
    end

    // R2 R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (chk_q == CNT_W'(LAT_SHORT) || chk_q == CNT_W'(LAT_LONG)));
    // R5
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/fdiv_lane.sv
`timescale 1ns/1ps
// fdiv_lane: one single-precision lane. It classifies the operands on load,
// runs restoring division one bit per step, and packs the quotient with
// round-toward-zero on fin. Subnormals are treated as zero; Inf/NaN inputs
// are assumed absent.
module fdiv_lane
    import fdiv_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic            fin,
    input  logic            active,
    input  logic [FP_W-1:0] op_a,
    input  logic [FP_W-1:0] op_b,
    output logic            zero_o,
    output logic [FP_W-1:0] res_o,
    output logic            dz_o
);
    localparam int unsigned REM_W = MANT_W + 1;

    logic a_zero, b_zero;
    logic act_q, sign_q, dz_q;
    op_kind_e kind_q, kind_in;
    logic signed [9:0] ediff_q, e_fin;
    logic [MANT_W-1:0] div_q;
    logic [REM_W-1:0]  rem_q, quo_q;
    logic [REM_W:0]    trial;
    logic              ge;
    logic [FRAC_W-1:0] frac;
    logic [FP_W-1:0]   packed_w, res_q;

    // Operand classification
    always_comb begin
        a_zero = (op_a[30:23] == '0);
        b_zero = (op_b[30:23] == '0);
        zero_o = a_zero || b_zero;
        if (a_zero && b_zero) kind_in = K_NAN;
        else if (a_zero)      kind_in = K_ZERO;
        else if (b_zero)      kind_in = K_INF;
        else                  kind_in = K_NORM;
    end

    // Restoring trial subtraction
    always_comb begin
        trial = {1'b0, rem_q} - {2'b00, div_q};
        ge    = !trial[REM_W];
    end

    // Normalize, range-check and pack the quotient
    always_comb begin
        e_fin = ediff_q - (quo_q[MANT_W] ? 10'sd0 : 10'sd1);
        frac  = quo_q[MANT_W] ? quo_q[MANT_W-1:1] : quo_q[MANT_W-2:0];
        if (kind_q != K_NORM)      packed_w = special_word(kind_q, sign_q);
        else if (e_fin >= 10'sd255) packed_w = special_word(K_INF, sign_q);
        else if (e_fin <= 10'sd0)   packed_w = special_word(K_ZERO, sign_q);
        else                        packed_w = {sign_q, e_fin[7:0], frac};
    end

    // Operand capture and division iteration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            sign_q  <= 1'b0;
            kind_q  <= K_NORM;
            ediff_q <= '0;
            div_q   <= '0;
            rem_q   <= '0;
            quo_q   <= '0;
        end else if (load) begin
            act_q   <= active;
            sign_q  <= op_a[31] ^ op_b[31];
            kind_q  <= kind_in;
            ediff_q <= $signed({2'b00, op_a[30:23]}) - $signed({2'b00, op_b[30:23]}) + 10'sd127;
            div_q   <= {1'b1, op_b[FRAC_W-1:0]};
            rem_q   <= {2'b01, op_a[FRAC_W-1:0]};
            quo_q   <= '0;
        end else if (step) begin
            rem_q <= ge ? {trial[MANT_W-1:0], 1'b0} : {rem_q[MANT_W-1:0], 1'b0};
            quo_q <= {quo_q[MANT_W-1:0], ge};
        end
    end

    // Result registers, updated at completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            dz_q  <= 1'b0;
        end else if (fin) begin
            res_q <= act_q ? packed_w : '0;
            dz_q  <= act_q && (kind_q == K_INF);
        end
    end

    assign res_o = res_q;
    assign dz_o  = dz_q;

    // R12
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !act_q) |=> (res_o == '0 && !dz_o));
endmodule

// File: rtl/fdiv_early_out.sv
`timescale 1ns/1ps
// fdiv_early_out: top of the operand-dependent latency divider. It builds the
// early-out decision across the lanes, instantiates one lane per LANES and a
// shared sequencer. Assumes the caller holds the operands only on the start cycle.
module fdiv_early_out #(
    parameter int unsigned LANES     = 2,
    parameter int unsigned LAT_SHORT = 4,
    parameter int unsigned LAT_LONG  = 29
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  vec_mode,
    input  logic [32*LANES-1:0]   op_a,
    input  logic [32*LANES-1:0]   op_b,
    output logic                  busy,
    output logic                  done,
    output logic [32*LANES-1:0]   result,
    output logic [LANES-1:0]      dz_flag
);
    localparam int unsigned ITERS = fdiv_pkg::MANT_W + 1;

    logic [LANES-1:0] lane_zero;
    logic early, load, step, fin;

    // Short path only when every participating lane has a zero operand
    always_comb begin
        early = vec_mode ? (&lane_zero) : lane_zero[0];
    end

    fdiv_ctrl #(
        .LAT_SHORT(LAT_SHORT),
        .LAT_LONG (LAT_LONG),
        .ITERS    (ITERS)
    ) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .early(early),
        .busy (busy),
        .done (done),
        .load (load),
        .step (step),
        .fin  (fin)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic act;
        if (g == 0) begin : g_first
            assign act = 1'b1;
        end else begin : g_rest
            assign act = vec_mode;
        end
        fdiv_lane u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .step  (step),
            .fin   (fin),
            .active(act),
            .op_a  (op_a[32*g +: 32]),
            .op_b  (op_b[32*g +: 32]),
            .zero_o(lane_zero[g]),
            .res_o (result[32*g +: 32]),
            .dz_o  (dz_flag[g])
        );
    end

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (done || ($stable(result) && $stable(dz_flag))));
endmodule

// File: tb/fdiv_early_out_tb.sv
`timescale 1ns/1ps
module fdiv_early_out_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        vec_mode = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        busy, done;
    logic [63:0] result;
    logic [1:0]  dz_flag;

    int errors = 0, checks = 0, cyc = 0, pushed = 0, popped = 0;
    logic prev_done = 1'b0;

    typedef struct {
        logic [63:0] res;
        logic [1:0]  dz;
        int          lat;
        int          t0;
        string       tag;
    } exp_t;
    exp_t sb[$];

    fdiv_early_out u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_mode(vec_mode),
        .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
        .result(result), .dz_flag(dz_flag)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // Reference lane model from the requirements
    function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b);
        logic s; logic [63:0] ma, mb, q; int e; logic [22:0] f;
        s = a[31] ^ b[31];
        if (a[30:23] == 0 && b[30:23] == 0) return {1'b0, 32'h7FC00000};
        if (a[30:23] == 0) return {1'b0, s, 31'h0};
        if (b[30:23] == 0) return {1'b1, s, 8'hFF, 23'h0};
        ma = {40'h0, 1'b1, a[22:0]};
        mb = {40'h0, 1'b1, b[22:0]};
        q  = (ma << 24) / mb;
        if (q[24]) begin e = int'(a[30:23]) - int'(b[30:23]) + 127; f = q[23:1]; end
        else       begin e = int'(a[30:23]) - int'(b[30:23]) + 126; f = q[22:0]; end
        if (e >= 255) return {1'b0, s, 8'hFF, 23'h0};
        if (e <= 0)   return {1'b0, s, 31'h0};
        return {1'b0, s, e[7:0], f};
    endfunction

    // Driver: compute expectation, push it, pulse start
    task automatic run_op(input logic vm, input logic [63:0] a, input logic [63:0] b, input string tag);
        exp_t it; logic [32:0] l0, l1; bit zl0, zl1;
        while (busy || done) @(negedge clk);
        l0  = model(a[31:0], b[31:0]);
        l1  = vm ? model(a[63:32], b[63:32]) : 33'h0;
        zl0 = (a[30:23] == 0) || (b[30:23] == 0);
        zl1 = (a[62:55] == 0) || (b[62:55] == 0);
        it.res = {l1[31:0], l0[31:0]};
        it.dz  = {l1[32], l0[32]};
        it.lat = (vm ? (zl0 && zl1) : zl0) ? 4 : 29;
        it.t0  = cyc + 1;
        it.tag = tag;
        sb.push_back(it);
        pushed++;
        vec_mode = vm; op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0; op_a = '0; op_b = '0;
        chk(busy === 1'b1, {tag, " R5 busy after accept"}, 64'(busy), 64'd1);
    endtask

    task automatic wait_idle();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pop and compare on each completion
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done) chk(1'b0, "R13 done wider than one cycle", 64'd1, 64'd0);
            if (done && !prev_done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R5 unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    popped++;
                    chk(result === it.res, {it.tag, " result"}, result, it.res);
                    chk(dz_flag === it.dz, {it.tag, " dz_flag"}, 64'(dz_flag), 64'(it.dz));
                    chk((cyc - it.t0) == it.lat, {it.tag, " latency"}, 64'(cyc - it.t0), 64'(it.lat));
                    chk(busy === 1'b0, {it.tag, " R5 busy low at done"}, 64'(busy), 64'd0);
                end
            end
            prev_done <= done;
        end
    end

    // Watchdog
    initial begin
        #(20 * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1 reset busy/done", {62'h0, busy, done}, 64'h0);
        chk(result === 64'h0 && dz_flag === 2'b00, "R1 reset result/dz", result, 64'h0);

        run_op(1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_4000_0000, "R2 R6 +0/2");
        run_op(1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_4000_0000, "R2 R6 -0/2");
        run_op(1'b0, 64'h0000_0000_4040_0000, 64'h0000_0000_8000_0000, "R2 R7 3/-0");
        run_op(1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, "R8 0/0");
        run_op(1'b0, 64'h0000_0000_40C0_0000, 64'h0000_0000_4000_0000, "R3 R9 6/2");
        run_op(1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_4040_0000, "R3 R9 1/3");
        run_op(1'b0, 64'h0000_0000_C0F0_0000, 64'h0000_0000_3F00_0000, "R9 -7.5/0.5");
        run_op(1'b0, 64'h0000_0000_4049_0FDB, 64'h0000_0000_C02D_F854, "R9 pi/-e");
        run_op(1'b0, 64'h0000_0000_7F00_0000, 64'h0000_0000_0080_0000, "R10 overflow");
        run_op(1'b0, 64'h0000_0000_0080_0000, 64'h0000_0000_7F00_0000, "R10 underflow");
        run_op(1'b0, 64'h0000_0000_0000_0001, 64'h0000_0000_4000_0000, "R11 subnormal dividend");
        run_op(1'b0, 64'h0000_0000_4000_0000, 64'h0000_0000_007F_FFFF, "R11 subnormal divisor");
        run_op(1'b0, 64'h4000_0000_4120_0000, 64'h0000_0000_4000_0000, "R12 upper ignored");
        run_op(1'b1, 64'h0000_0000_4040_0000, 64'h4000_0000_0000_0000, "R4 both lanes zero");
        run_op(1'b1, 64'h0000_0000_4040_0000, 64'h4000_0000_4000_0000, "R4 one lane zero");
        run_op(1'b1, 64'hBF80_0000_4120_0000, 64'h4040_0000_4000_0000, "R4 R9 vector normal");
        wait_idle();

        // R5: start during a long operation is ignored
        run_op(1'b0, 64'h0000_0000_4120_0000, 64'h0000_0000_4040_0000, "R5 running op");
        repeat (5) @(negedge clk);
        vec_mode = 1'b1; op_a = 64'h0; op_b = 64'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; vec_mode = 1'b0;
        wait_idle();
        repeat (40) @(negedge clk);
        chk(popped == pushed, "R5 no extra completion", 64'(popped), 64'(pushed));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule